// File: doc/BRIEF.md
# Multi-Threshold Temperature Interrupt Unit

This block watches one temperature channel. Each 12-bit sample arrives with a valid strobe. The block compares the sample against five programmable thresholds: hot, normal-to-hot, cold, upper band edge and lower band edge. Any condition that is met latches a sticky status bit. Software clears a status bit by writing a one to it. A per-bit enable register masks the status bits, and the masked bits are ORed into one interrupt line.

The hot and normal-to-hot conditions share a single trigger level. That level is the larger of the two thresholds, and both status bits latch together when a sample rises above it. If the normal-to-hot register holds zero, the cold threshold replaces it when the trigger level is chosen. A sixth bit, no-hot, marks the sample that takes the channel from above the trigger level back to it or below.

Configuration goes through a simple write port with a 3-bit address. Address 0 is the enable mask and address 1 is the write-one-to-clear status port. Addresses 2 to 6 are the hot, normal-to-hot, cold, upper band and lower band thresholds, in that order. A write to address 7 has no effect.

Top module: `temp_thresh_irq`

## Requirements
- R1: After reset, status is 0, irq is 0 and the enable mask is 0. The thresholds reset to hot 4095, normal-to-hot 0, cold 0, upper band 4095 and lower band 0, so no sample can set any status bit.
- R2: The trigger level is the larger of the hot threshold (address 2) and the effective normal-to-hot threshold. A valid sample strictly above the trigger level sets status bit 0 (hot) and bit 5 (normal-to-hot) in the same cycle. A sample equal to the level sets neither bit.
- R3: When the normal-to-hot register (address 3) holds 0, the cold threshold (address 4) stands in as the effective normal-to-hot threshold.
- R4: A valid sample strictly below the cold threshold sets status bit 1.
- R5: A valid sample strictly above the upper band threshold (address 5) sets bit 2. A valid sample strictly below the lower band threshold (address 6) sets bit 3. Equality sets neither bit.
- R6: A valid sample at or below the trigger level sets bit 4 (no-hot), but only when the previous valid sample was above the trigger level.
- R7: A status bit, once set, stays set until it is cleared, whatever later samples show.
- R8: Writing to address 1 clears each status bit whose data bit is 1. Data bits that are 0 leave the matching status bits unchanged.
- R9: When a set and a clear reach the same status bit in the same cycle, the set wins.
- R10: irq is high exactly when some status bit and its enable bit (address 0, bits 5:0) are both 1. Changing the enable mask never alters status.
- R11: Samples presented while the valid input is low have no effect on status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Temperature sample code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| status | output | 6 | Sticky status bits |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest state to reach from the ports is the no-hot bit, because it depends on a hidden flag left by the previous valid sample. The stimulus first drives a hot sample, clears status, then drives a cooler sample. It repeats the cool sample to show that the bit fires only on the transition. The second hard case is a clear colliding with a set on the same bit. The bench reaches it by asserting a sample strobe and a status write in the same cycle.

// File: rtl/tti_pkg.sv
package tti_pkg;
   localparam int EVT_N  = 6;
   localparam int ADDR_W = 3;

   // status bit positions
   localparam int B_HOT   = 0;
   localparam int B_COLD  = 1;
   localparam int B_UPPER = 2;
   localparam int B_LOWER = 3;
   localparam int B_NOHOT = 4;
   localparam int B_N2H   = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_ENABLE = 3'd0,
      A_CLEAR  = 3'd1,
      A_HOT    = 3'd2,
      A_N2H    = 3'd3,
      A_COLD   = 3'd4,
      A_UPPER  = 3'd5,
      A_LOWER  = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/tti_regs.sv
module tti_regs
   import tti_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [EVT_N-1:0]    en_q,
   output logic [EVT_N-1:0]    clr_vec,
   output logic [DATA_W-1:0]   hot_q,
   output logic [DATA_W-1:0]   n2h_q,
   output logic [DATA_W-1:0]   cold_q,
   output logic [DATA_W-1:0]   upper_q,
   output logic [DATA_W-1:0]   lower_q
);
   localparam logic [DATA_W-1:0] T_MAX = '1;
   localparam logic [DATA_W-1:0] T_MIN = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         hot_q   <= T_MAX;
         n2h_q   <= T_MIN;
         cold_q  <= T_MIN;
         upper_q <= T_MAX;
         lower_q <= T_MIN;
      end else if (wr_en) begin
         case (wr_addr)
            A_ENABLE: en_q    <= wr_data[EVT_N-1:0];
            A_HOT:    hot_q   <= wr_data;
            A_N2H:    n2h_q   <= wr_data;
            A_COLD:   cold_q  <= wr_data;
            A_UPPER:  upper_q <= wr_data;
            A_LOWER:  lower_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      clr_vec = '0;
      if (wr_en && wr_addr == A_CLEAR) clr_vec = wr_data[EVT_N-1:0];
   end
endmodule

// File: rtl/tti_compare.sv
module tti_compare
   import tti_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [DATA_W-1:0]  smp_data,
   input  logic [DATA_W-1:0]  hot_q,
   input  logic [DATA_W-1:0]  n2h_q,
   input  logic [DATA_W-1:0]  cold_q,
   input  logic [DATA_W-1:0]  upper_q,
   input  logic [DATA_W-1:0]  lower_q,
   output logic [EVT_N-1:0]   set_vec
);
   logic [DATA_W-1:0] eff_n2h;
   logic [DATA_W-1:0] trig_lvl;
   logic              above;
   logic              was_above;

   always_comb begin
      eff_n2h  = (n2h_q == '0) ? cold_q : n2h_q;
      trig_lvl = (hot_q > eff_n2h) ? hot_q : eff_n2h;
      above    = smp_data > trig_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         was_above <= 1'b0;
      else if (smp_valid) was_above <= above;
   end

   always_comb begin
      set_vec          = '0;
      set_vec[B_HOT]   = smp_valid && above;
      set_vec[B_N2H]   = smp_valid && above;
      set_vec[B_COLD]  = smp_valid && (smp_data < cold_q);
      set_vec[B_UPPER] = smp_valid && (smp_data > upper_q);
      set_vec[B_LOWER] = smp_valid && (smp_data < lower_q);
      set_vec[B_NOHOT] = smp_valid && !above && was_above;
   end
endmodule

// File: rtl/tti_status.sv
module tti_status
   import tti_pkg::*;
#(
   parameter int REG_IRQ = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_N-1:0]  set_vec,
   input  logic [EVT_N-1:0]  clr_vec,
   input  logic [EVT_N-1:0]  en_q,
   output logic [EVT_N-1:0]  status,
   output logic              irq
);
   for (genvar b = 0; b < EVT_N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          status[b] <= 1'b0;
         else if (set_vec[b]) status[b] <= 1'b1;
         else if (clr_vec[b]) status[b] <= 1'b0;
      end
   end

   logic irq_c;
   assign irq_c = |(status & en_q);

   if (REG_IRQ != 0) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end
endmodule

// File: rtl/temp_thresh_irq.sv
module temp_thresh_irq
   import tti_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int REG_IRQ = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [DATA_W-1:0]  smp_data,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [5:0]         status,
   output logic               irq
);
   if (DATA_W < EVT_N || DATA_W > 32) begin : g_bad_width
      $error("temp_thresh_irq: DATA_W must lie in 6..32");
   end
   if (REG_IRQ != 0 && REG_IRQ != 1) begin : g_bad_opt
      $error("temp_thresh_irq: REG_IRQ must be 0 or 1");
   end

   logic [EVT_N-1:0]  en_q, clr_vec, set_vec;
   logic [DATA_W-1:0] hot_q, n2h_q, cold_q, upper_q, lower_q;

   tti_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .en_q(en_q), .clr_vec(clr_vec),
      .hot_q(hot_q), .n2h_q(n2h_q), .cold_q(cold_q),
      .upper_q(upper_q), .lower_q(lower_q)
   );

   tti_compare #(.DATA_W(DATA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .hot_q(hot_q), .n2h_q(n2h_q), .cold_q(cold_q),
      .upper_q(upper_q), .lower_q(lower_q), .set_vec(set_vec)
   );

   tti_status #(.REG_IRQ(REG_IRQ)) u_sts (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .en_q(en_q), .status(status), .irq(irq)
   );
endmodule

// File: rtl/tti_chk.sv
module tti_chk
   import tti_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int REG_IRQ = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_valid,
   input logic [DATA_W-1:0]  smp_data,
   input logic               wr_en,
   input logic [2:0]         wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic [5:0]         status,
   input logic               irq,
   input logic [EVT_N-1:0]   en_q,
   input logic [DATA_W-1:0]  cold_q
);
   AST_HOT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (status[B_HOT] && !$past(status[B_HOT])) |-> status[B_N2H]); // R2

   AST_COLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_data < cold_q) |=> status[B_COLD]); // R4

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[B_UPPER] && !(wr_en && wr_addr == A_CLEAR && wr_data[B_UPPER]))
      |=> status[B_UPPER]); // R7

   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CLEAR && wr_data[B_LOWER] && !smp_valid)
      |=> !status[B_LOWER]); // R8

   AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_IRQ != 0) || (irq == |(status & en_q))); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ((status | $past(status)) == $past(status))); // R11
endmodule

bind temp_thresh_irq tti_chk #(.DATA_W(DATA_W), .REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .status(status),
   .irq(irq), .en_q(en_q), .cold_q(cold_q)
);

// File: tb/test_temp_thresh_irq.sv
module test_temp_thresh_irq;
   localparam int CLK_P = 10;
   localparam int DW    = 12;
   localparam int NV    = 10;

   // {hot, n2h, cold, upper, lower, sample, expected status}
   localparam logic [77:0] VECS [0:NV-1] = '{
      {12'd800,  12'd700,  12'd100,  12'd4095, 12'd0,   12'd900,  6'h21},
      {12'd800,  12'd1000, 12'd100,  12'd4095, 12'd0,   12'd900,  6'h00},
      {12'd800,  12'd1000, 12'd100,  12'd4095, 12'd0,   12'd1001, 6'h21},
      {12'd800,  12'd0,    12'd1200, 12'd4095, 12'd0,   12'd900,  6'h02},
      {12'd800,  12'd0,    12'd1200, 12'd4095, 12'd0,   12'd1300, 6'h21},
      {12'd4095, 12'd0,    12'd0,    12'd500,  12'd0,   12'd600,  6'h04},
      {12'd4095, 12'd0,    12'd0,    12'd4095, 12'd500, 12'd400,  6'h08},
      {12'd800,  12'd800,  12'd800,  12'd800,  12'd800, 12'd800,  6'h00},
      {12'd4095, 12'd0,    12'd0,    12'd4095, 12'd0,   12'd0,    6'h00},
      {12'd4094, 12'd1,    12'd0,    12'd4095, 12'd0,   12'd4095, 6'h21}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [5:0]    status;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   temp_thresh_irq i_temp_thresh_irq (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status(status), .irq(irq)
   );

   task automatic do_rst();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic smp(input logic [DW-1:0] s);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = s;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic chk(input string req, input logic [5:0] exp_s, input logic exp_i);
      checks++;
      if (status !== exp_s || irq !== exp_i) begin
         errors++;
         $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                  req, status, irq, exp_s, exp_i);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state, and reset thresholds keep every bit quiet
      do_rst();
      chk("R1 reset", 6'h00, 1'b0);
      wr(3'd0, 12'h03F);
      smp(12'd2048);
      chk("R1 quiet thresholds", 6'h00, 1'b0);

      // vector table: R2 R3 R4 R5 R10
      for (int i = 0; i < NV; i++) begin
         logic [77:0] v;
         v = VECS[i];
         do_rst();
         wr(3'd0, 12'h03F);
         wr(3'd2, v[77:66]);
         wr(3'd3, v[65:54]);
         wr(3'd4, v[53:42]);
         wr(3'd5, v[41:30]);
         wr(3'd6, v[29:18]);
         smp(v[17:6]);
         chk($sformatf("R2 R3 R4 R5 vector %0d", i), v[5:0], |v[5:0]);
      end

      // R6 no-hot only on the transition out of hot
      do_rst();
      wr(3'd0, 12'h03F);
      wr(3'd2, 12'd800);
      wr(3'd3, 12'd700);
      smp(12'd900);
      chk("R6 hot first", 6'h21, 1'b1);
      wr(3'd1, 12'h03F);
      smp(12'd700);
      chk("R6 no-hot transition", 6'h10, 1'b1);
      wr(3'd1, 12'h03F);
      smp(12'd700);
      chk("R6 no repeat", 6'h00, 1'b0);

      // R7 sticky, R8 partial clear, R10 mask, R9 set over clear, R11 idle
      do_rst();
      wr(3'd0, 12'h03F);
      wr(3'd5, 12'd500);
      smp(12'd600);
      chk("R5 upper", 6'h04, 1'b1);
      smp(12'd400);
      chk("R7 sticky", 6'h04, 1'b1);
      wr(3'd6, 12'd300);
      smp(12'd200);
      chk("R5 lower", 6'h0C, 1'b1);
      wr(3'd1, 12'h004);
      chk("R8 partial clear", 6'h08, 1'b1);
      wr(3'd0, 12'h008);
      chk("R10 enabled bit", 6'h08, 1'b1);
      wr(3'd0, 12'h004);
      chk("R10 masked bit", 6'h08, 1'b0);
      wr(3'd0, 12'h03F);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = 12'd200;
      wr_en = 1'b1; wr_addr = 3'd1; wr_data = 12'h00C;
      @(negedge clk);
      smp_valid = 1'b0; wr_en = 1'b0;
      chk("R9 set beats clear", 6'h08, 1'b1);
      wr(3'd1, 12'h03F);
      chk("R8 clear all", 6'h00, 1'b0);
      @(negedge clk);
      smp_data = 12'd200;
      repeat (3) @(negedge clk);
      chk("R11 invalid sample ignored", 6'h00, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule